// File: doc/BRIEF.md
# SONET Serial-to-Parallel Frame Aligner

This block converts a serial bit stream, one bit per cycle of a fast clock, into parallel words of `W` bits (32 by default) at one word per `W` fast cycles. The first bit of each group goes to the most significant output bit. After reset the word boundary falls on the first bit after reset, so the block behaves as a plain 1:W demultiplexer.

When alignment search is enabled (`align_hold` low), a detector examines a sliding window of the last 2·W bits at every fast cycle. It looks for the framing run of four A1 bytes followed by four A2 bytes. When the run is found, a barrel shifter moves the word boundary so that a parallel word ends exactly on the bit that completed the match. The word strobe is dropped once during this realignment, and a sync flag marks the word holding the third group of four A2 bytes. Driving `align_hold` high freezes the current boundary. The usual sequence is to enable search, wait for sync, then hold.

Each output word also carries a parity bit. It covers the data word and the sync flag, and its sense (odd or even) is chosen by an input.

Top module: `sonet_frame_aligner`

## Requirements
- R1: After reset the first serial bit received is output on `word_o[W-1]` and the W-th on `word_o[0]`. The first strobe follows the W-th fast edge after reset release.
- R2: Outside a realignment, `word_stb` is a single-cycle pulse that repeats every W fast cycles.
- R3: A match requires a window of the last 2·W bits (oldest first) whose bytes are A1 (0xF6) four times and then A2 (0x28) four times. Only byte bits 7 and 3 (bit 7 being the earlier bit) of each byte are compared. A match while `align_hold` is low moves the boundary so that output words end on the bit that completed the match.
- R4: A realignment suppresses exactly one strobe. The strobe that carries the word ending on the match bit is kept, the next one is dropped, and the one after that is delivered.
- R5: `sync_o` is set for exactly one output word: the word ending 2·W bits after the match bit, which for W=32 is 0x28282828. It is set only if `align_hold` is low when that word is loaded.
- R6: While `align_hold` is high, no match is taken. The word boundary stays where it was, no strobe is dropped and `sync_o` stays low.
- R7: Reset (active low) clears the boundary offset to zero and drives `word_o`, `word_stb`, `sync_o` and `par_o` low.
- R8: The ones in `word_o`, `sync_o` and `par_o` together are even when `par_even` was high at the load edge and odd when it was low.
- R9: `word_o`, `sync_o` and `par_o` change only on the edge that raises `word_stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data, one bit per clock |
| align_hold | input | 1 | High: freeze the word boundary and suppress the frame search |
| par_even | input | 1 | Parity sense: high even, low odd |
| word_o | output | W | Aligned parallel word, first bit in the MSB |
| word_stb | output | 1 | One-cycle strobe marking a new word |
| sync_o | output | 1 | Frame sync flag, valid with the word |
| par_o | output | 1 | Parity over the word and the sync flag |

## Verification
Known words sent straight after reset with the search held show the MSB-first ordering and the zero offset. A full framing run sent with the search held must leave the boundary, the strobe spacing and sync untouched. Framing runs at two different bit misalignments with the search enabled show the one dropped strobe, the sync word and the parity sense. A marker word placed on the locked boundary, before and after a held framing run, shows whether the offset was kept.

// File: rtl/fa_pkg.sv
package fa_pkg;
  // Byte bits compared by the frame detector (bit 7 is received first)
  localparam int unsigned FA_MARK_HI = 7;
  localparam int unsigned FA_MARK_LO = 3;

  // Realignment progress, counted in raw word boundaries
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_SYNC_NEXT = 2'd1,
    ST_SKIP_NEXT = 2'd2,
    ST_ARMED     = 2'd3
  } realign_st_t;
endpackage

// File: rtl/fa_deser.sv
module fa_deser #(
  parameter int unsigned W = 32,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_in,
  output logic [CW-1:0] pos,
  output logic          boundary,
  output logic [W-1:0]  cur_word,
  output logic [W-2:0]  prev_lo
);
  logic [CW-1:0] pos_n;
  logic [W-2:0]  sreg_q, sreg_n;
  logic [W-2:0]  prev_n;

  always_comb begin
    cur_word = {sreg_q, ser_in};
    boundary = (pos == CW'(W - 1));
    pos_n    = pos + CW'(1);
    sreg_n   = cur_word[W-2:0];
    prev_n   = boundary ? cur_word[W-2:0] : prev_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      sreg_q  <= '0;
      prev_lo <= '0;
    end else begin
      pos     <= pos_n;
      sreg_q  <= sreg_n;
      prev_lo <= prev_n;
    end
  end
endmodule

// File: rtl/fa_detect.sv
module fa_detect #(
  parameter int unsigned W     = 32,
  parameter logic [7:0]  A1    = 8'hF6,
  parameter logic [7:0]  A2    = 8'h28,
  localparam int unsigned WIN  = 2 * W,
  localparam int unsigned NB   = WIN / 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  output logic match
);
  import fa_pkg::*;

  function automatic logic [WIN-1:0] build_pat(input bit want_mask);
    logic [WIN-1:0] v;
    logic [7:0]     b;
    v = '0;
    for (int i = 0; i < NB; i++) begin
      b = (i < NB / 2) ? A1 : A2;
      if (want_mask) b = 8'h00 | (8'h1 << FA_MARK_HI) | (8'h1 << FA_MARK_LO);
      v[WIN-1-8*i -: 8] = b;
    end
    return v;
  endfunction

  localparam logic [WIN-1:0] PAT  = build_pat(1'b0);
  localparam logic [WIN-1:0] MASK = build_pat(1'b1);

  logic [WIN-2:0] hist_q, hist_n;
  logic [WIN-1:0] win;

  always_comb begin
    win    = {hist_q, ser_in};
    hist_n = win[WIN-2:0];
    match  = (((win ^ PAT) & MASK) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_n;
  end
endmodule

// File: rtl/fa_bshift.sv
module fa_bshift #(
  parameter int unsigned W = 32,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic [W-2:0]  prev_lo,
  input  logic [W-1:0]  cur_word,
  input  logic [CW-1:0] shift,
  output logic [W-1:0]  aligned
);
  logic [2*W-2:0] cat;
  logic [W-1:0]   cand [W];

  assign cat = {prev_lo, cur_word};

  for (genvar s = 0; s < W; s++) begin : g_tap
    assign cand[s] = cat[s +: W];
  end

  assign aligned = cand[shift];
endmodule

// File: rtl/sonet_frame_aligner.sv
module sonet_frame_aligner #(
  parameter int unsigned W  = 32,
  parameter logic [7:0]  A1 = 8'hF6,
  parameter logic [7:0]  A2 = 8'h28,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         align_hold,
  input  logic         par_even,
  output logic [W-1:0] word_o,
  output logic         word_stb,
  output logic         sync_o,
  output logic         par_o
);
  import fa_pkg::*;

  logic [CW-1:0] pos;
  logic          boundary;
  logic [W-1:0]  cur_word;
  logic [W-2:0]  prev_lo;
  logic          match;
  logic [W-1:0]  aligned;

  logic [CW-1:0] shift_q, shift_n;
  realign_st_t   st_q, st_n;
  logic          det, skip, load;
  logic [W-1:0]  word_n;
  logic          sync_n, par_n;

  fa_deser #(.W(W)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_in   (ser_in),
    .pos      (pos),
    .boundary (boundary),
    .cur_word (cur_word),
    .prev_lo  (prev_lo)
  );

  fa_detect #(.W(W), .A1(A1), .A2(A2)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .ser_in (ser_in),
    .match  (match)
  );

  // The offset used for this boundary is the next-state value, so a match
  // on the boundary bit itself already takes effect on that word.
  fa_bshift #(.W(W)) u_bshift (
    .prev_lo  (prev_lo),
    .cur_word (cur_word),
    .shift    (shift_n),
    .aligned  (aligned)
  );

  always_comb begin
    det     = match & ~align_hold;
    shift_n = det ? (CW'(W - 1) - pos) : shift_q;

    st_n = st_q;
    if (det) begin
      st_n = boundary ? ST_SKIP_NEXT : ST_ARMED;
    end else if (boundary) begin
      case (st_q)
        ST_ARMED:     st_n = ST_SKIP_NEXT;
        ST_SKIP_NEXT: st_n = ST_SYNC_NEXT;
        default:      st_n = ST_IDLE;
      endcase
    end

    skip   = boundary & ~det & (st_q == ST_SKIP_NEXT);
    load   = boundary & ~skip;
    sync_n = ~det & ~align_hold & (st_q == ST_SYNC_NEXT);
    word_n = aligned;
    par_n  = (^{aligned, sync_n}) ^ ~par_even;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      st_q     <= ST_IDLE;
      word_stb <= 1'b0;
      word_o   <= '0;
      sync_o   <= 1'b0;
      par_o    <= 1'b0;
    end else begin
      shift_q  <= shift_n;
      st_q     <= st_n;
      word_stb <= load;
      if (load) begin
        word_o <= word_n;
        sync_o <= sync_n;
        par_o  <= par_n;
      end
    end
  end
endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
  parameter int unsigned W  = 32,
  localparam int unsigned CW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          align_hold,
  input logic          par_even,
  input logic [W-1:0]  word_o,
  input logic          word_stb,
  input logic          sync_o,
  input logic          par_o,
  input logic [CW-1:0] shift_q
);
  // R2: strobe lasts a single cycle
  assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb);

  // R9: outputs only move with the strobe
  assert_hold_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |-> ($stable(word_o) && $stable(sync_o) && $stable(par_o)));

  // R8: total parity follows the select sampled at the load edge
  assert_parity_sense_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> ((^{word_o, sync_o, par_o}) == !$past(par_even)));

  // R5: sync is never loaded while the search is held
  assert_sync_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && sync_o) |-> !$past(align_hold));

  // R6: holding the search freezes the offset
  assert_offset_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    align_hold |=> $stable(shift_q));
endmodule

bind sonet_frame_aligner fa_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .align_hold (align_hold),
  .par_even   (par_even),
  .word_o     (word_o),
  .word_stb   (word_stb),
  .sync_o     (sync_o),
  .par_o      (par_o),
  .shift_q    (shift_q)
);

// File: tb/sonet_frame_aligner_bench.sv
module sonet_frame_aligner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk, rst_n, ser_in, align_hold, par_even;
  logic [W-1:0] word_o;
  logic         word_stb, sync_o, par_o;

  sonet_frame_aligner #(.W(W)) u_sonet_frame_aligner (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .align_hold(align_hold),
    .par_even(par_even), .word_o(word_o), .word_stb(word_stb),
    .sync_o(sync_o), .par_o(par_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  // Reference model state
  bit           bits[$];
  int           m_shift, m_cd;
  logic [W-1:0] e_word;
  bit           e_stb, e_sync, e_par;

  // Observation state
  int cyc = 0, last_stb = -1, gaps = 0, odd_gaps = 0, syncs = 0;
  logic [W-1:0] sync_word;
  bit sync_par, saw_marker;
  int n_lock;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit model_match(int n);
    logic [7:0] pb;
    if (n < 2*W - 1) return 0;
    for (int i = 0; i < 2*W/8; i++) begin
      pb = (i < W/8) ? 8'hF6 : 8'h28;
      if (bits[n-2*W+1+8*i]   != pb[7]) return 0;
      if (bits[n-2*W+1+8*i+4] != pb[3]) return 0;
    end
    return 1;
  endfunction

  task automatic model_edge(input bit b);
    int n, p, idx, ones;
    bit det, bnd, skip, syn;
    bits.push_back(b);
    n = bits.size() - 1;
    p = n % W;
    bnd = (p == W - 1);
    det = !align_hold && model_match(n);
    if (det) m_shift = W - 1 - p;
    e_stb = 0;
    if (bnd) begin
      skip = (m_cd == 2) && !det;
      syn  = (m_cd == 1) && !det && !align_hold;
      if (!skip) begin
        e_stb = 1;
        for (int j = 0; j < W; j++) begin
          idx = n - m_shift - (W - 1) + j;
          e_word[W-1-j] = (idx >= 0) ? bits[idx] : 1'b0;
        end
        e_sync = syn;
        ones = $countones({e_word, e_sync});
        e_par = par_even ? (ones % 2 == 1) : (ones % 2 == 0);
      end
    end
    if (det) m_cd = bnd ? 2 : 3;
    else if (bnd && m_cd > 0) m_cd--;
  endtask

  task automatic step(input bit b);
    ser_in = b;
    @(posedge clk);
    model_edge(b);
    @(negedge clk);
    cyc++;
    check(word_stb == e_stb, "R2 R4", "strobe", word_stb, e_stb);
    check(word_o == e_word, "R1 R3 R9", "word", word_o, e_word);
    check(sync_o == e_sync, "R5", "sync", sync_o, e_sync);
    check(par_o == e_par, "R8", "parity", par_o, e_par);
    if (word_stb) begin
      if (last_stb >= 0) begin
        if (cyc - last_stb == 2*W) gaps++;
        else if (cyc - last_stb != W) odd_gaps++;
      end
      last_stb = cyc;
      if (sync_o) begin syncs++; sync_word = word_o; sync_par = par_o; end
      if (word_o == 32'hCAFEF00D) saw_marker = 1;
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) step(v[i]);
  endtask

  task automatic send_word(input logic [W-1:0] v);
    for (int i = W-1; i >= 0; i--) step(v[i]);
  endtask

  task automatic send_zeros(input int k);
    for (int i = 0; i < k; i++) step(1'b0);
  endtask

  task automatic send_frame();
    for (int i = 0; i < 48; i++) send_byte(8'hF6);
    for (int i = 0; i < 4; i++) send_byte(8'h28);
    n_lock = bits.size() - 1;
    for (int i = 0; i < 44; i++) send_byte(8'h28);
  endtask

  task automatic clear_obs();
    gaps = 0; odd_gaps = 0; syncs = 0; saw_marker = 0; sync_word = '0;
  endtask

  task automatic marker_on_lock(input int lock_bit);
    while ((bits.size() % W) != ((lock_bit + 1) % W)) step(1'b0);
    saw_marker = 0;
    send_word(32'hCAFEF00D);
    send_zeros(2*W);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lock_a;
    rst_n = 0; ser_in = 0; align_hold = 1; par_even = 0;
    m_shift = 0; m_cd = 0; e_word = '0; e_stb = 0; e_sync = 0; e_par = 0;
    repeat (20) @(negedge clk);
    // R7: reset state
    check(word_o == '0, "R7", "reset word", word_o, 0);
    check(!word_stb && !sync_o && !par_o, "R7", "reset flags",
          {word_stb, sync_o, par_o}, 0);
    rst_n = 1;

    // R1: plain demux ordering straight after reset
    send_word(32'hDEADBEEF);
    check(word_stb && word_o == 32'hDEADBEEF, "R1", "first word", word_o, 32'hDEADBEEF);
    send_word(32'h0F1E2D3C);
    check(word_o == 32'h0F1E2D3C, "R1", "second word", word_o, 32'h0F1E2D3C);

    // R6: framing run with search held
    clear_obs();
    send_zeros(11); send_frame(); send_zeros(200);
    check(gaps == 0, "R6", "held gaps", gaps, 0);
    check(syncs == 0, "R6", "held syncs", syncs, 0);
    check(odd_gaps == 0, "R2", "strobe spacing", odd_gaps, 0);

    // R3 R4 R5: search enabled, even parity
    align_hold = 0; par_even = 1;
    clear_obs();
    send_zeros(13); send_frame(); lock_a = n_lock; send_zeros(300);
    check(gaps == 1, "R4", "dropped strobes", gaps, 1);
    check(syncs == 1, "R5", "sync count", syncs, 1);
    check(sync_word == 32'h28282828, "R3 R5", "sync word", sync_word, 32'h28282828);
    check(sync_par == 1'b1, "R8", "even parity on sync", sync_par, 1);
    check(odd_gaps == 0, "R2", "strobe spacing", odd_gaps, 0);
    align_hold = 1;
    marker_on_lock(lock_a);
    check(saw_marker, "R3", "marker on locked boundary", saw_marker, 1);

    // R6: held run at another misalignment keeps the old boundary
    clear_obs();
    send_zeros(7); send_frame(); send_zeros(150);
    check(gaps == 0 && syncs == 0, "R6", "held run gaps+syncs", gaps + syncs, 0);
    marker_on_lock(lock_a);
    check(saw_marker, "R6", "offset kept", saw_marker, 1);

    // Second realignment, odd parity
    align_hold = 0; par_even = 0;
    clear_obs();
    send_zeros(5); send_frame(); send_zeros(300);
    check(gaps == 1, "R4", "dropped strobes 2", gaps, 1);
    check(syncs == 1, "R5", "sync count 2", syncs, 1);
    check(sync_word == 32'h28282828, "R5", "sync word 2", sync_word, 32'h28282828);
    check(sync_par == 1'b0, "R8", "odd parity on sync", sync_par, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule